// File: doc/BRIEF.md
# Character Display Write Controller

This block drives a two-row, sixteen-column character display over an eight-bit parallel bus. It only ever writes. Once reset is released it configures the display by itself. It sends four setup commands, which select the 8-bit bus with two lines and a 5x7 font, turn the display on with the cursor hidden, set auto-increment entry, and clear the screen. It then waits a settle interval before it takes any input.

A host then streams character codes through a valid/ready handshake. Each accepted code goes out as one character write. The controller tracks the cursor column and row itself. When a line fills, it inserts the address command that moves the cursor to the start of the other line, so the host never has to send cursor commands.

Every transfer follows the same pattern. The bus and the register-select line are set up first. Enable is then held high and then low for an equal number of clock cycles, set by a parameter. The display latches the byte on the falling edge of enable.

Top module: `charlcd_writer`

## Requirements
- R1: `lcd_rw` is 0 at all times. `lcd_rs` is 0 during every command byte and 1 during every character byte.
- R2: `lcd_data` and `lcd_rs` hold the same value from the cycle before `lcd_en` rises until the first cycle after `lcd_en` falls.
- R3: In each transfer, `lcd_en` is high for exactly `HALF_CYCLES` clock cycles. It then stays low for at least `HALF_CYCLES` cycles before it rises again.
- R4: After reset is released, the first four writes are the commands 0x38, 0x0C, 0x06 and 0x01, in that order. `char_ready` stays low until `init_done` is high.
- R5: `init_done` rises exactly `HALF_CYCLES` cycles after `lcd_en` falls on the 0x01 command. It then stays high until the next reset.
- R6: `char_ready` first rises exactly `SETTLE_CYCLES` cycles after `init_done` rises.
- R7: A code is accepted when `char_valid` and `char_ready` are both high at a rising clock edge. Each accepted code is written to the display exactly once, in order of acceptance, with the same eight-bit value on `lcd_data`.
- R8: `char_ready` is low whenever a character write or a cursor command is in progress. A `char_valid` pulse that is raised and dropped while `char_ready` is low produces no write.
- R9: After the 16th character of row 0 is written, the command 0xC0 is written before any further character. After the 16th character of row 1 is written, the command 0x80 is written. In both cases the column count starts again from zero.
- R10: The synchronous active-high `rst` forces `lcd_en`, `char_ready` and `init_done` low at the first clock edge where it is sampled high. Once released, the setup sequence runs again from its first command, and the cursor is back at row 0, column 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| char_valid | input | 1 | Host offers a character code |
| char_data | input | 8 | Character code from the host |
| char_ready | output | 1 | Controller can accept a code this cycle |
| lcd_data | output | 8 | Parallel data bus to the display |
| lcd_rs | output | 1 | Register select: 0 for command, 1 for character |
| lcd_rw | output | 1 | Read/write select, held at write (0) |
| lcd_en | output | 1 | Enable strobe; the display latches on its falling edge |
| init_done | output | 1 | Power-up command sequence has completed |

## Verification
The hardest case to reach from the ports is a reset that lands in the middle of a strobe after the cursor has moved away from column zero. The test has to show that no half-finished write is reported and that the column count really returns to zero. The bench first sends a few characters, then raises reset while enable is high. It then checks that exactly sixteen more characters pass before the 0xC0 command appears. Line wrap in both directions is reached by feeding directed runs of exactly sixteen characters, mixed with random codes and random gaps between offers. Ignored handshakes are provoked by pulsing `char_valid` with a marker code while a transfer is in flight.

// File: rtl/charlcd_pkg.sv
package charlcd_pkg;

    localparam int BYTE_W   = 8;
    localparam int INIT_LEN = 4;
    localparam int IDX_W    = $clog2(INIT_LEN);

    typedef logic [BYTE_W-1:0] lcd_byte_t;

    // setup commands, sent in this order after reset
    localparam lcd_byte_t CMD_FUNC     = 8'h38;  // 8-bit bus, two lines, 5x7 font
    localparam lcd_byte_t CMD_DISPLAY  = 8'h0C;  // display on, cursor hidden
    localparam lcd_byte_t CMD_ENTRY    = 8'h06;  // auto-increment entry
    localparam lcd_byte_t CMD_CLEAR    = 8'h01;  // clear screen
    localparam lcd_byte_t CMD_SET_ADDR = 8'h80;  // OR-ed with the character address

    function automatic lcd_byte_t init_cmd(input logic [IDX_W-1:0] idx);
        lcd_byte_t c;
        unique case (idx)
            2'd0:    c = CMD_FUNC;
            2'd1:    c = CMD_DISPLAY;
            2'd2:    c = CMD_ENTRY;
            default: c = CMD_CLEAR;
        endcase
        return c;
    endfunction

    typedef enum logic [1:0] {
        STB_IDLE,
        STB_SETUP,
        STB_HIGH,
        STB_LOW
    } stb_phase_e;

    typedef enum logic [2:0] {
        SEQ_BOOT,
        SEQ_BOOT_WAIT,
        SEQ_SETTLE,
        SEQ_IDLE,
        SEQ_CHAR_WAIT,
        SEQ_MOVE,
        SEQ_MOVE_WAIT
    } seq_phase_e;

endpackage

// File: rtl/charlcd_strobe.sv
module charlcd_strobe
    import charlcd_pkg::*;
#(
    parameter int unsigned HALF_CYCLES = 1_000_000
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  lcd_byte_t byte_in,
    input  logic      rs_in,
    output lcd_byte_t bus,
    output logic      rs,
    output logic      en,
    output logic      done
);

    localparam int unsigned CNT_W = $clog2(HALF_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_CYCLES - 1);

    typedef struct packed {
        stb_phase_e       phase;
        logic [CNT_W-1:0] cnt;
        lcd_byte_t        bus;
        logic             rs;
        logic             en;
    } stb_t;

    localparam stb_t STB_RST = '{phase: STB_IDLE, cnt: '0, bus: '0, rs: 1'b0, en: 1'b0};

    stb_t stb_d, stb_q;

    always_comb begin
        stb_d = stb_q;
        done  = 1'b0;
        unique case (stb_q.phase)
            STB_IDLE: begin
                if (start) begin
                    // bus is set one cycle ahead of the enable edge
                    stb_d.bus   = byte_in;
                    stb_d.rs    = rs_in;
                    stb_d.phase = STB_SETUP;
                end
            end
            STB_SETUP: begin
                stb_d.en    = 1'b1;
                stb_d.cnt   = '0;
                stb_d.phase = STB_HIGH;
            end
            STB_HIGH: begin
                if (stb_q.cnt == CNT_LAST) begin
                    stb_d.en    = 1'b0;
                    stb_d.cnt   = '0;
                    stb_d.phase = STB_LOW;
                end else begin
                    stb_d.cnt = stb_q.cnt + CNT_W'(1);
                end
            end
            STB_LOW: begin
                if (stb_q.cnt == CNT_LAST) begin
                    stb_d.cnt   = '0;
                    stb_d.phase = STB_IDLE;
                    done        = 1'b1;
                end else begin
                    stb_d.cnt = stb_q.cnt + CNT_W'(1);
                end
            end
            default: stb_d = STB_RST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) stb_q <= STB_RST;
        else     stb_q <= stb_d;
    end

    assign bus = stb_q.bus;
    assign rs  = stb_q.rs;
    assign en  = stb_q.en;

endmodule

// File: rtl/charlcd_cursor.sv
module charlcd_cursor
    import charlcd_pkg::*;
#(
    parameter int unsigned COLS = 16,
    parameter int unsigned ROWS = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      step,
    output logic      line_full,
    output lcd_byte_t line_cmd
);

    localparam int unsigned COL_W = (COLS > 1) ? $clog2(COLS) : 1;
    localparam int unsigned ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);
    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);

    typedef struct packed {
        logic [COL_W-1:0] col;
        logic [ROW_W-1:0] row;
    } cur_t;

    cur_t cur_d, cur_q;

    // odd rows start at 0x40; rows 2 and 3 follow a line further on
    function automatic lcd_byte_t addr_cmd(input logic [ROW_W-1:0] r);
        int unsigned base;
        base = (int'(r) % 2) * 64 + (int'(r) / 2) * COLS;
        return CMD_SET_ADDR | lcd_byte_t'(base);
    endfunction

    always_comb begin
        cur_d = cur_q;
        if (step) begin
            if (cur_q.col == COL_LAST) begin
                cur_d.col = '0;
                cur_d.row = (cur_q.row == ROW_LAST) ? '0 : cur_q.row + ROW_W'(1);
            end else begin
                cur_d.col = cur_q.col + COL_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur_q <= '0;
        else     cur_q <= cur_d;
    end

    assign line_full = (cur_q.col == COL_LAST);
    assign line_cmd  = addr_cmd(cur_q.row);

endmodule

// File: rtl/charlcd_writer.sv
module charlcd_writer
    import charlcd_pkg::*;
#(
    parameter int unsigned HALF_CYCLES   = 1_000_000,
    parameter int unsigned SETTLE_CYCLES = 100_000,
    parameter int unsigned COLS          = 16,
    parameter int unsigned ROWS          = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       char_valid,
    input  logic [7:0] char_data,
    output logic       char_ready,
    output logic [7:0] lcd_data,
    output logic       lcd_rs,
    output logic       lcd_rw,
    output logic       lcd_en,
    output logic       init_done
);

    localparam int unsigned SET_W = $clog2(SETTLE_CYCLES + 1);
    localparam logic [SET_W-1:0] SET_LAST = SET_W'(SETTLE_CYCLES - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(INIT_LEN - 1);

    typedef struct packed {
        seq_phase_e       phase;
        logic [IDX_W-1:0] boot_idx;
        logic [SET_W-1:0] settle;
        logic             init_done;
    } seq_t;

    localparam seq_t SEQ_RST = '{phase: SEQ_BOOT, boot_idx: '0, settle: '0, init_done: 1'b0};

    seq_t      seq_d, seq_q;
    logic      stb_start, stb_rs, stb_done, stb_en, stb_rs_out;
    lcd_byte_t stb_byte, stb_bus;
    logic      cur_step, cur_full;
    lcd_byte_t cur_cmd;

    charlcd_strobe #(.HALF_CYCLES(HALF_CYCLES)) u_strobe (
        .clk     (clk),
        .rst     (rst),
        .start   (stb_start),
        .byte_in (stb_byte),
        .rs_in   (stb_rs),
        .bus     (stb_bus),
        .rs      (stb_rs_out),
        .en      (stb_en),
        .done    (stb_done)
    );

    charlcd_cursor #(.COLS(COLS), .ROWS(ROWS)) u_cursor (
        .clk       (clk),
        .rst       (rst),
        .step      (cur_step),
        .line_full (cur_full),
        .line_cmd  (cur_cmd)
    );

    always_comb begin
        seq_d      = seq_q;
        stb_start  = 1'b0;
        stb_byte   = init_cmd(seq_q.boot_idx);
        stb_rs     = 1'b0;
        cur_step   = 1'b0;
        char_ready = 1'b0;
        unique case (seq_q.phase)
            SEQ_BOOT: begin
                stb_start   = 1'b1;
                seq_d.phase = SEQ_BOOT_WAIT;
            end
            SEQ_BOOT_WAIT: begin
                if (stb_done) begin
                    if (seq_q.boot_idx == IDX_LAST) begin
                        seq_d.init_done = 1'b1;
                        seq_d.settle    = '0;
                        seq_d.phase     = SEQ_SETTLE;
                    end else begin
                        seq_d.boot_idx = seq_q.boot_idx + IDX_W'(1);
                        seq_d.phase    = SEQ_BOOT;
                    end
                end
            end
            SEQ_SETTLE: begin
                if (seq_q.settle == SET_LAST) seq_d.phase  = SEQ_IDLE;
                else                          seq_d.settle = seq_q.settle + SET_W'(1);
            end
            SEQ_IDLE: begin
                char_ready = 1'b1;
                stb_byte   = char_data;
                stb_rs     = 1'b1;
                if (char_valid) begin
                    stb_start   = 1'b1;
                    seq_d.phase = SEQ_CHAR_WAIT;
                end
            end
            SEQ_CHAR_WAIT: begin
                if (stb_done) begin
                    cur_step    = 1'b1;
                    seq_d.phase = cur_full ? SEQ_MOVE : SEQ_IDLE;
                end
            end
            SEQ_MOVE: begin
                // cursor has already stepped to the new row
                stb_byte    = cur_cmd;
                stb_start   = 1'b1;
                seq_d.phase = SEQ_MOVE_WAIT;
            end
            SEQ_MOVE_WAIT: begin
                if (stb_done) seq_d.phase = SEQ_IDLE;
            end
            default: seq_d = SEQ_RST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) seq_q <= SEQ_RST;
        else     seq_q <= seq_d;
    end

    assign lcd_data  = stb_bus;
    assign lcd_rs    = stb_rs_out;
    assign lcd_en    = stb_en;
    assign lcd_rw    = 1'b0;
    assign init_done = seq_q.init_done;

endmodule

// File: rtl/charlcd_writer_chk.sv
module charlcd_writer_chk #(
    parameter int unsigned HALF_CYCLES = 1_000_000
) (
    input logic       clk,
    input logic       rst,
    input logic       lcd_en,
    input logic       lcd_rs,
    input logic [7:0] lcd_data,
    input logic       char_ready,
    input logic       init_done
);

    logic        past_rst_q;
    int unsigned hi_cnt_q;
    int unsigned lo_cnt_q;

    always_ff @(posedge clk) begin
        past_rst_q <= rst;
        if (rst) begin
            hi_cnt_q <= 0;
            lo_cnt_q <= HALF_CYCLES;
        end else if (lcd_en) begin
            hi_cnt_q <= hi_cnt_q + 1;
            lo_cnt_q <= 0;
        end else begin
            hi_cnt_q <= 0;
            if (lo_cnt_q < HALF_CYCLES) lo_cnt_q <= lo_cnt_q + 1;
        end
    end

    AST_BUS_SETUP: assert property (@(posedge clk) disable iff (rst || past_rst_q)
        $rose(lcd_en) |-> ($stable(lcd_data) && $stable(lcd_rs))); // R2

    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (rst || past_rst_q)
        $past(lcd_en) |-> ($stable(lcd_data) && $stable(lcd_rs))); // R2

    AST_HIGH_WIDTH: assert property (@(posedge clk) disable iff (rst || past_rst_q)
        $fell(lcd_en) |-> (hi_cnt_q == HALF_CYCLES)); // R3

    AST_LOW_GAP: assert property (@(posedge clk) disable iff (rst || past_rst_q)
        $rose(lcd_en) |-> (lo_cnt_q >= HALF_CYCLES)); // R3

    AST_BOOT_CMD_ONLY: assert property (@(posedge clk) disable iff (rst)
        (!init_done && lcd_en) |-> !lcd_rs); // R4

    AST_NO_READY_IN_BOOT: assert property (@(posedge clk) disable iff (rst)
        !init_done |-> !char_ready); // R4

    AST_INIT_STICKY: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done); // R5

    AST_READY_QUIET: assert property (@(posedge clk) disable iff (rst)
        char_ready |-> !lcd_en); // R8

endmodule

bind charlcd_writer charlcd_writer_chk #(.HALF_CYCLES(HALF_CYCLES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .lcd_en     (lcd_en),
    .lcd_rs     (lcd_rs),
    .lcd_data   (lcd_data),
    .char_ready (char_ready),
    .init_done  (init_done)
);

// File: tb/charlcd_writer_bench.sv
module charlcd_writer_bench;

    localparam int HALF   = 3;
    localparam int SETTLE = 5;
    localparam int COLS   = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       char_valid = 1'b0;
    logic [7:0] char_data = 8'h00;
    logic       char_ready, lcd_rs, lcd_rw, lcd_en, init_done;
    logic [7:0] lcd_data;

    always #2.5 clk = ~clk;

    charlcd_writer #(
        .HALF_CYCLES   (HALF),
        .SETTLE_CYCLES (SETTLE),
        .COLS          (COLS),
        .ROWS          (2)
    ) u_charlcd_writer (
        .clk        (clk),
        .rst        (rst),
        .char_valid (char_valid),
        .char_data  (char_data),
        .char_ready (char_ready),
        .lcd_data   (lcd_data),
        .lcd_rs     (lcd_rs),
        .lcd_rw     (lcd_rw),
        .lcd_en     (lcd_en),
        .init_done  (init_done)
    );

    int         checks = 0;
    int         bad = 0;
    int         cyc = 0;
    int         last_fall_cyc = 0;
    logic [8:0] exp_q[$];
    int         col_m = 0;
    int         row_m = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] row_cmd(input int r);
        return (r == 1) ? 8'hC0 : 8'h80;
    endfunction

    task automatic model_reset();
        exp_q.delete();
        col_m = 0;
        row_m = 0;
        exp_q.push_back({1'b0, 8'h38});
        exp_q.push_back({1'b0, 8'h0C});
        exp_q.push_back({1'b0, 8'h06});
        exp_q.push_back({1'b0, 8'h01});
    endtask

    task automatic model_char(input logic [7:0] b);
        exp_q.push_back({1'b1, b});
        col_m++;
        if (col_m == COLS) begin
            col_m = 0;
            row_m = (row_m + 1) % 2;
            exp_q.push_back({1'b0, row_cmd(row_m)});
        end
    endtask

    // bus monitor: decodes every completed write at the falling enable
    logic       en_prev = 1'b0;
    logic       rs_prev = 1'b0;
    logic [7:0] d_prev = 8'h00;
    int         hi = 0;
    int         lo = 0;
    bit         first = 1'b1;
    bit         moved = 1'b0;

    always @(negedge clk) begin
        if (rst) begin
            hi = 0; lo = 0; first = 1'b1; moved = 1'b0;
        end else begin
            if (lcd_en && !en_prev) begin
                if (!first) check(lo >= HALF, "R3 low gap", lo, HALF);
                check(lcd_data == d_prev && lcd_rs == rs_prev, "R2 setup", {lcd_rs, lcd_data}, {rs_prev, d_prev});
                hi = 1; moved = 1'b0; first = 1'b0;
            end else if (lcd_en) begin
                hi++;
                if (lcd_data != d_prev || lcd_rs != rs_prev) moved = 1'b1;
            end else if (en_prev) begin
                logic [8:0] e;
                check(hi == HALF, "R3 high width", hi, HALF);
                check(!moved && lcd_data == d_prev && lcd_rs == rs_prev, "R2 hold", {lcd_rs, lcd_data}, {rs_prev, d_prev});
                check(lcd_rw == 1'b0, "R1 rw level", lcd_rw, 0);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7 unexpected write", {lcd_rs, lcd_data}, 0);
                end else begin
                    e = exp_q.pop_front();
                    check({lcd_rs, lcd_data} == e, "R1/R7/R9 write", {lcd_rs, lcd_data}, e);
                end
                last_fall_cyc = cyc;
                lo = 1;
            end else begin
                lo++;
            end
            if (char_ready && lcd_en) check(1'b0, "R8 ready while strobing", 1, 0);
            if (!init_done && char_ready) check(1'b0, "R4 ready before init", 1, 0);
        end
        en_prev = rst ? 1'b0 : lcd_en;
        d_prev  = lcd_data;
        rs_prev = lcd_rs;
    end

    task automatic wait_init();
        int n;
        while (!init_done) @(negedge clk);
        check(exp_q.size() == 0, "R4 setup commands written", exp_q.size(), 0);
        check(cyc - last_fall_cyc == HALF, "R5 init_done timing", cyc - last_fall_cyc, HALF);
        n = 0;
        while (!char_ready) begin
            @(negedge clk);
            n++;
            check(init_done, "R5 init_done held", init_done, 1);
        end
        check(n == SETTLE, "R6 settle interval", n, SETTLE);
    endtask

    task automatic send(input logic [7:0] b, input int gap);
        repeat (gap) @(negedge clk);
        char_valid = 1'b1;
        char_data  = b;
        while (!char_ready) @(negedge clk);
        model_char(b);
        @(negedge clk);
        char_valid = 1'b0;
        char_data  = 8'($urandom);
    endtask

    // valid offered and withdrawn while a transfer is running
    task automatic stray_pulse();
        check(!char_ready, "R8 ready low in transfer", char_ready, 0);
        char_valid = 1'b1;
        char_data  = 8'hFF;
        repeat (2) @(negedge clk);
        char_valid = 1'b0;
    endtask

    task automatic drain();
        int n;
        n = 0;
        while ((exp_q.size() != 0 || !char_ready) && n < 200) begin
            @(negedge clk);
            n++;
        end
        check(exp_q.size() == 0, "R7 all writes observed", exp_q.size(), 0);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", checks, bad);
    endtask

    initial begin
        void'($urandom(32'h1CD0_5EED));
        model_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(!lcd_en && !char_ready && !init_done, "R10 reset state", {lcd_en, char_ready, init_done}, 0);
        check(lcd_rw == 1'b0, "R1 rw in reset", lcd_rw, 0);
        rst = 1'b0;
        wait_init();

        // directed: exactly one full row 0, then row 1, forcing both wraps (R9)
        for (int i = 0; i < COLS; i++) send(8'h41 + 8'(i), 0);
        drain();
        for (int i = 0; i < COLS; i++) send(8'h61 + 8'(i), i % 2);
        drain();

        // random codes and gaps, with stray valid pulses (R7, R8)
        for (int i = 0; i < 40; i++) begin
            send(8'($urandom_range(32, 126)), $urandom_range(0, 3));
            if (i % 7 == 3) stray_pulse();
        end
        drain();

        // reset in the middle of a strobe with the cursor mid-line (R10)
        for (int i = 0; i < 5; i++) send(8'h30 + 8'(i), 0);
        @(negedge clk);
        check(lcd_en, "R10 reset lands mid strobe", lcd_en, 1);
        rst = 1'b1;
        model_reset();
        @(negedge clk);
        check(!lcd_en && !char_ready && !init_done, "R10 reset clears outputs", {lcd_en, char_ready, init_done}, 0);
        @(negedge clk);
        rst = 1'b0;
        wait_init();
        for (int i = 0; i < COLS + 2; i++) send(8'($urandom_range(32, 126)), $urandom_range(0, 2));
        drain();

        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        bad++;
        $display("FAIL watchdog R7 actual=hung expected=finished");
        summary();
        $finish;
    end

endmodule